// File: doc/BRIEF.md
# Dual-Bus Control Register with Serial-EEPROM Bit Control

This block is one 32-bit control and status word that two host buses can write: a primary port and a local port. The word stores four default bus command codes for the DMA and direct-master engines and drives a general-purpose output pin. It also shows the level of a general-purpose input pin. Software can set the clock, chip-select and data-in lines of a serial EEPROM one bit at a time, and can read the EEPROM's data-out line and its presence flag.

The same word holds three system controls. The first asks for a configuration reload, as a single pulse. The second holds the local side in software reset. The third is a local-init-done flag that decides whether primary-bus accesses are answered with retry. A write is applied at the clock edge where it is presented. The read word is combinational from the stored state and the synchronized inputs. When both ports write in the same cycle, the primary port wins.

Top module: `dual_port_ctrl_reg`

## Requirements
- R1: After reset the read word is 0x0001767E when `eePresent` is 0. The fields are: bits 3:0 = 4'hE, bits 7:4 = 4'h7, bits 11:8 = 4'h6, bits 15:12 = 4'h7, bit 16 = 1, and all other bits 0.
- R2: A write from either port loads bits 15:0 into the four command outputs at the next clock edge. `dmaRdCmd` takes bits 3:0, `dmaWrCmd` takes 7:4, `dmRdCmd` takes 11:8 and `dmWrCmd` takes 15:12.
- R3: Bit 16 is writable and drives `gpOut`. Bit 17 shows `gpIn` after two clock edges of synchronization.
- R4: Bits 23:18 always read 0. Writes to bits 17, 27 and 28 have no effect on what those bits read.
- R5: Bits 24, 25 and 26 are writable and drive `eeClk`, `eeCs` and `eeDataIn`. Bit 27 shows `eeDataOut` after two clock edges. Bit 28 shows `eePresent` directly.
- R6: A write with bit 29 set, while bit 29 reads 0, sets bit 29 and drives `reloadReq` high for exactly one cycle after that edge. A write of 1 while bit 29 reads 1 gives no pulse. A write of 0 to bit 29 has no effect. An asserted `reloadDone` clears bit 29 at the next edge.
- R7: While bit 30 is 1, `localResetN` is 0. Either port may set bit 30. Only a primary-port write can clear it.
- R8: While bit 30 is 1, every local-port write is ignored in full.
- R9: When both ports write in the same cycle, only the primary-port data is stored.
- R10: `priRetry` is high exactly when `priAccess` is high and bit 31 reads 0. It is combinational in the same cycle.
- R11: While `strapN`, after two clock edges of synchronization, is low, bit 31 reads 1 whatever value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| priWrEn | input | 1 | Primary-port write strobe |
| priWrData | input | 32 | Primary-port write word |
| locWrEn | input | 1 | Local-port write strobe |
| locWrData | input | 32 | Local-port write word |
| priAccess | input | 1 | A primary-bus access to the device is in progress |
| priRetry | output | 1 | Answer the primary access with retry |
| rdData | output | 32 | Current register word (shared by both ports) |
| gpIn | input | 1 | General-purpose input pin |
| gpOut | output | 1 | General-purpose output pin |
| eeDataOut | input | 1 | Serial data from the EEPROM |
| eePresent | input | 1 | EEPROM fitted |
| eeClk | output | 1 | EEPROM serial clock |
| eeCs | output | 1 | EEPROM chip select |
| eeDataIn | output | 1 | Serial data to the EEPROM |
| reloadDone | input | 1 | Configuration loader finished the reload |
| reloadReq | output | 1 | One-cycle configuration-reload request |
| strapN | input | 1 | Active-low strap that forces init done |
| localResetN | output | 1 | Active-low software reset for the local side |
| dmaRdCmd | output | 4 | DMA read command code |
| dmaWrCmd | output | 4 | DMA write command code |
| dmRdCmd | output | 4 | Direct-master read command code |
| dmWrCmd | output | 4 | Direct-master write command code |

## Verification
The pulse and hold properties assume that `reloadDone` is asserted only after a request has been issued. They also assume that `priAccess` is driven only with settled values between clock edges. The stimulus keeps to both assumptions. It raises `reloadDone` for one cycle only after a pulse has been seen, and it changes every input just after a rising edge, with the asynchronous inputs held for at least two edges. The bench feeds overlapping writes from the two ports on purpose, to check arbitration. No write arrives while reset is asserted.

// File: rtl/dpcr_pkg.sv
`timescale 1ns/1ps
package dpcr_pkg;
  localparam int REG_W    = 32;
  localparam int CMD_W    = 16;
  localparam int F_GPO    = 16;
  localparam int F_GPI    = 17;
  localparam int F_ECLK   = 24;
  localparam int F_ECS    = 25;
  localparam int F_EDI    = 26;
  localparam int F_EDO    = 27;
  localparam int F_EPRES  = 28;
  localparam int F_RELOAD = 29;
  localparam int F_SWRST  = 30;
  localparam int F_INIT   = 31;

  // Write strobes passed from the arbitration control to the datapath.
  typedef struct packed {
    logic             wr;
    logic             fromPri;
    logic             reloadSet;
    logic [CMD_W-1:0] cmd;
    logic             gpo;
    logic [2:0]       ee;
    logic             swRst;
    logic             init;
  } wrStrobe_t;
endpackage

// File: rtl/dpcr_sync.sv
`timescale 1ns/1ps
module dpcr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RESET_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dpcr_ctrl.sv
`timescale 1ns/1ps
module dpcr_ctrl
  import dpcr_pkg::*;
(
  input  logic             priWrEn,
  input  logic [REG_W-1:0] priWrData,
  input  logic             locWrEn,
  input  logic [REG_W-1:0] locWrData,
  input  logic             swRstNow,
  input  logic             reloadNow,
  output wrStrobe_t        strobe
);
  logic [REG_W-1:0] selData;
  logic             unusedBits;

  always_comb begin
    strobe  = '0;
    selData = '0;
    if (priWrEn) begin
      strobe.wr      = 1'b1;
      strobe.fromPri = 1'b1;
      selData        = priWrData;
    end else if (locWrEn && !swRstNow) begin
      strobe.wr = 1'b1;
      selData   = locWrData;
    end
    strobe.cmd       = selData[CMD_W-1:0];
    strobe.gpo       = selData[F_GPO];
    strobe.ee        = selData[F_EDI:F_ECLK];
    strobe.swRst     = selData[F_SWRST];
    strobe.init      = selData[F_INIT];
    strobe.reloadSet = strobe.wr && selData[F_RELOAD] && !reloadNow;
  end

  assign unusedBits = ^{selData[23:17], selData[F_EPRES:F_EDO]};
endmodule

// File: rtl/dpcr_datapath.sv
`timescale 1ns/1ps
module dpcr_datapath
  import dpcr_pkg::*;
#(
  parameter logic [CMD_W-1:0] CMD_RESET = 16'h767E,
  parameter logic             GPO_RESET = 1'b1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  input  logic             reloadDone,
  input  logic             gpIn,
  input  logic             eeDataOut,
  input  logic             strapN,
  input  logic             eePresent,
  output logic             swRstNow,
  output logic             reloadNow,
  output logic             reloadReq,
  output logic [REG_W-1:0] word
);
  logic [CMD_W-1:0] cmdReg;
  logic             gpoReg;
  logic [2:0]       eeReg;
  logic             initReg;
  logic [2:0]       syncOut;

  dpcr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({strapN, eeDataOut, gpIn}),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= CMD_RESET;
      gpoReg    <= GPO_RESET;
      eeReg     <= '0;
      initReg   <= 1'b0;
      swRstNow  <= 1'b0;
      reloadNow <= 1'b0;
      reloadReq <= 1'b0;
    end else begin
      reloadReq <= strobe.reloadSet;
      if (strobe.reloadSet)  reloadNow <= 1'b1;
      else if (reloadDone)   reloadNow <= 1'b0;
      if (strobe.wr) begin
        cmdReg  <= strobe.cmd;
        gpoReg  <= strobe.gpo;
        eeReg   <= strobe.ee;
        initReg <= strobe.init;
        if (strobe.fromPri)    swRstNow <= strobe.swRst;
        else if (strobe.swRst) swRstNow <= 1'b1;
      end
    end
  end

  assign word = {initReg | ~syncOut[2], swRstNow, reloadNow, eePresent,
                 syncOut[1], eeReg, 6'b0, syncOut[0], gpoReg, cmdReg};
endmodule

// File: rtl/dual_port_ctrl_reg.sv
`timescale 1ns/1ps
module dual_port_ctrl_reg
  import dpcr_pkg::*;
#(
  parameter logic [CMD_W-1:0] CMD_RESET = 16'h767E,
  parameter int               SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        priWrEn,
  input  logic [31:0] priWrData,
  input  logic        locWrEn,
  input  logic [31:0] locWrData,
  input  logic        priAccess,
  output logic        priRetry,
  output logic [31:0] rdData,
  input  logic        gpIn,
  output logic        gpOut,
  input  logic        eeDataOut,
  input  logic        eePresent,
  output logic        eeClk,
  output logic        eeCs,
  output logic        eeDataIn,
  input  logic        reloadDone,
  output logic        reloadReq,
  input  logic        strapN,
  output logic        localResetN,
  output logic [3:0]  dmaRdCmd,
  output logic [3:0]  dmaWrCmd,
  output logic [3:0]  dmRdCmd,
  output logic [3:0]  dmWrCmd
);
  wrStrobe_t strobe;
  logic      swRstNow;
  logic      reloadNow;

  dpcr_ctrl u_ctrl (
    .priWrEn(priWrEn), .priWrData(priWrData),
    .locWrEn(locWrEn), .locWrData(locWrData),
    .swRstNow(swRstNow), .reloadNow(reloadNow),
    .strobe(strobe)
  );

  dpcr_datapath #(.CMD_RESET(CMD_RESET), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadDone(reloadDone),
    .gpIn(gpIn), .eeDataOut(eeDataOut), .strapN(strapN), .eePresent(eePresent),
    .swRstNow(swRstNow), .reloadNow(reloadNow), .reloadReq(reloadReq),
    .word(rdData)
  );

  assign priRetry    = priAccess & ~rdData[F_INIT];
  assign localResetN = ~swRstNow;
  assign gpOut       = rdData[F_GPO];
  assign eeClk       = rdData[F_ECLK];
  assign eeCs        = rdData[F_ECS];
  assign eeDataIn    = rdData[F_EDI];
  assign dmaRdCmd    = rdData[3:0];
  assign dmaWrCmd    = rdData[7:4];
  assign dmRdCmd     = rdData[11:8];
  assign dmWrCmd     = rdData[15:12];
endmodule

// File: rtl/dpcr_checker.sv
`timescale 1ns/1ps
module dpcr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        priWrEn,
  input logic        locWrEn,
  input logic        priAccess,
  input logic        priRetry,
  input logic [31:0] rdData,
  input logic        gpOut,
  input logic [3:0]  dmaRdCmd,
  input logic        reloadReq
);
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[23:18] == 6'd0);

  p_reload_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |=> !reloadReq);

  p_reload_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |-> rdData[29]);

  p_swrst_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[30] && !priWrEn) |=> rdData[30]);

  p_loc_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[30] && locWrEn && !priWrEn) |=> ($stable(gpOut) && $stable(dmaRdCmd)));

  p_retry_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (priAccess && !rdData[31]) |-> priRetry);

  p_retry_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    priRetry |-> (priAccess && !rdData[31]));
endmodule

bind dual_port_ctrl_reg dpcr_checker u_chk (
  .clk(clk), .rstN(rstN), .priWrEn(priWrEn), .locWrEn(locWrEn),
  .priAccess(priAccess), .priRetry(priRetry), .rdData(rdData),
  .gpOut(gpOut), .dmaRdCmd(dmaRdCmd), .reloadReq(reloadReq)
);

// File: tb/dual_port_ctrl_reg_test.sv
`timescale 1ns/1ps
module dual_port_ctrl_reg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        priWrEn = 0, locWrEn = 0, priAccess = 0;
  logic [31:0] priWrData = 0, locWrData = 0;
  logic        gpIn = 0, eeDataOut = 0, eePresent = 0, reloadDone = 0, strapN = 1;
  logic        priRetry, gpOut, eeClk, eeCs, eeDataIn, reloadReq, localResetN;
  logic [31:0] rdData;
  logic [3:0]  dmaRdCmd, dmaWrCmd, dmRdCmd, dmWrCmd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_port_ctrl_reg uut (.*);

  // {port (1 = primary, 2 = local), write word, expected read word}
  localparam int NV = 5;
  localparam logic [65:0] VEC [NV] = '{
    {2'd1, 32'h0000_0000, 32'h0000_0000},
    {2'd2, 32'h8FFF_FFFF, 32'h8701_FFFF},
    {2'd1, 32'h0000_1234, 32'h0000_1234},
    {2'd2, 32'h0201_A5C3, 32'h0201_A5C3},
    {2'd1, 32'h8000_0000, 32'h8000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int port, input logic [31:0] d);
    if (port == 1) begin priWrEn = 1; priWrData = d; end
    else begin locWrEn = 1; locWrData = d; end
    @(posedge clk); #1;
    priWrEn = 0; locWrEn = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (400) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5 rstN = 1; tick();
    // R1 reset state
    check("R1 reset word", rdData, 32'h0001_767E);
    check("R1 localResetN", {31'd0, localResetN}, 32'd1);

    // Table walk: R2 R4 R5 R3 field behaviour
    for (int i = 0; i < NV; i++) begin
      wr(int'(VEC[i][65:64]), VEC[i][63:32]);
      check("R4 table read word", rdData, VEC[i][31:0]);
      check("R2 command outputs", {16'd0, dmWrCmd, dmRdCmd, dmaWrCmd, dmaRdCmd},
            {16'd0, VEC[i][15:0]});
      check("R3 gpOut", {31'd0, gpOut}, {31'd0, VEC[i][16]});
      check("R5 eeprom outs", {29'd0, eeDataIn, eeCs, eeClk}, {29'd0, VEC[i][26:24]});
    end

    // R3 gpIn sync, R5 eeDataOut sync and eePresent
    wr(1, 32'h0);
    gpIn = 1; eeDataOut = 1; eePresent = 1;
    #0.5;
    check("R5 eePresent direct", {31'd0, rdData[28]}, 32'd1);
    tick();
    check("R3 gpIn after one edge", {30'd0, rdData[27], rdData[17]}, 32'd0);
    tick();
    check("R3 R5 inputs after two edges", {30'd0, rdData[27], rdData[17]}, 32'd3);
    wr(2, 32'h0);
    check("R4 read-only bits ignore writes", {29'd0, rdData[28:27], rdData[17]}, 32'd7);
    gpIn = 0; eeDataOut = 0; eePresent = 0; tick(); tick();

    // R6 reload request
    wr(1, 32'h2000_0000);
    check("R6 pulse high", {31'd0, reloadReq}, 32'd1);
    check("R6 bit set", {31'd0, rdData[29]}, 32'd1);
    tick();
    check("R6 pulse one cycle", {31'd0, reloadReq}, 32'd0);
    wr(1, 32'h2000_0000);
    check("R6 no pulse when set", {31'd0, reloadReq}, 32'd0);
    wr(1, 32'h0);
    check("R6 write zero no effect", {31'd0, rdData[29]}, 32'd1);
    reloadDone = 1; tick(); reloadDone = 0;
    check("R6 cleared by done", {31'd0, rdData[29]}, 32'd0);

    // R7 / R8 software reset
    wr(2, 32'h4000_0000);
    check("R7 local sets swrst", {31'd0, localResetN}, 32'd0);
    wr(2, 32'h0001_FFFF);
    check("R8 local write ignored", rdData, 32'h4000_0000);
    check("R7 local cannot clear", {31'd0, localResetN}, 32'd0);
    wr(1, 32'h0000_5555);
    check("R7 primary clears", {31'd0, localResetN}, 32'd1);

    // R9 simultaneous writes
    priWrEn = 1; priWrData = 32'h0000_0111;
    locWrEn = 1; locWrData = 32'h0000_0222;
    tick(); priWrEn = 0; locWrEn = 0;
    check("R9 primary wins", rdData, 32'h0000_0111);

    // R10 retry gating
    priAccess = 1; #0.5;
    check("R10 retry while not init", {31'd0, priRetry}, 32'd1);
    wr(2, 32'h8000_0000);
    check("R10 no retry after init", {31'd0, priRetry}, 32'd0);
    priAccess = 0; #0.5;
    check("R10 no retry without access", {31'd0, priRetry}, 32'd0);

    // R11 strap forces init
    wr(1, 32'h0); priAccess = 1;
    strapN = 0; tick();
    check("R11 strap after one edge", {31'd0, rdData[31]}, 32'd0);
    tick();
    check("R11 strap forces init", {31'd0, rdData[31]}, 32'd1);
    check("R11 R10 retry released", {31'd0, priRetry}, 32'd0);
    strapN = 1; priAccess = 0; tick(); tick();
    check("R11 strap released", {31'd0, rdData[31]}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule